// File: doc/BRIEF.md
# Thread-Aware Branch Predictor

This block predicts the next fetch address for a front end shared by several hardware threads. A prediction is a combinational lookup. It takes a thread number and a fetch PC, and it returns a hit flag, a taken flag and a target. Three structures feed the lookup:

- a set-associative target buffer whose entries record the thread that owns them;
- a table of two-bit saturating counters, indexed by the word address XORed with a global outcome history;
- one return-address stack for each thread.

Resolved branches come back on the update port. Each carries its thread, PC, outcome, target and kind. The update trains the counters and the history, allocates or refreshes buffer entries, and pushes or pops the owning thread's stack. The new state is visible to predictions from the next cycle onwards.

Top module: `mtbp_predictor`

## Requirements
- R1: After reset every buffer entry is invalid, every counter holds 1, the history is zero and every stack is empty. A prediction therefore reports hit 0, taken 0 and target PC+4.
- R2: The buffer has 64 sets of 4 ways. The set is PC[7:2] and the tag is PC[31:8]. A lookup hits only when the tag and the thread number both match, so an entry owned by another thread never hits.
- R3: An update that is not taken and misses in the buffer leaves the buffer unchanged. Entries are allocated only for taken updates that miss.
- R4: On a buffer miss, taken is 0, hit is 0 and the target is PC+4.
- R5: On a hit with kind 0 (conditional), the prediction reads the counter at index PC[12:2] XOR history. A counter value of 2 or 3 gives taken with the stored target. A value of 0 or 1 gives not-taken with PC+4.
- R6: A conditional update moves the counter at index upd_pc[12:2] XOR history (the history before the shift) one step toward the outcome. The counter saturates at 0 and 3. The 11-bit history then shifts left and takes the outcome into bit 0. Updates of other kinds leave the history and the counters alone.
- R7: The kind encoding is 0 conditional, 1 jump, 2 call, 3 return. A hit of kind 1 or 2 predicts taken with the stored target.
- R8: A hit of kind 3 predicts taken, with the target at the top of the requesting thread's stack. If that stack is empty, it predicts not-taken with PC+4.
- R9: A call update pushes upd_pc+4 onto the updating thread's stack. A return update pops it, and a pop on an empty stack does nothing. Each stack holds 12 entries, and a push onto a full stack overwrites the oldest entry.
- R10: Allocation fills the lowest-numbered invalid way of the set. If no way is invalid, it replaces the least recently updated way. A hitting update marks its way most recent, and it rewrites the target and kind only when taken.
- R11: A prediction made in the same cycle as an update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_tid_i | input | 2 | Thread requesting a prediction |
| pred_pc_i | input | 32 | Fetch PC to predict |
| pred_taken_o | output | 1 | Predicted taken |
| pred_target_o | output | 32 | Predicted next fetch address |
| pred_hit_o | output | 1 | Target buffer hit |
| upd_valid_i | input | 1 | Resolved branch present |
| upd_tid_i | input | 2 | Thread of the resolved branch |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_target_i | input | 32 | Resolved target |
| upd_type_i | input | 2 | Branch kind: 0 cond, 1 jump, 2 call, 3 return |

## Verification
Prediction and update can fall in the same cycle, and they can touch the same set, counter or stack. The bench provokes this in directed steps. In one step a prediction asks for a PC in the very cycle its allocating update arrives. In another, return predictions are made while the same thread's return updates pop the stack. The random phase keeps both ports busy on a small pool of aliasing PCs. The reference model is always evaluated before it applies the cycle's update, so a result is judged correct only if it reflects the old state.

// File: rtl/mtbp_pkg.sv
`timescale 1ns/1ps
package mtbp_pkg;
  typedef enum logic [1:0] {
    BR_COND = 2'd0,
    BR_JUMP = 2'd1,
    BR_CALL = 2'd2,
    BR_RET  = 2'd3
  } br_kind_e;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/mtbp_btb.sv
`timescale 1ns/1ps
module mtbp_btb import mtbp_pkg::*; #(
  parameter int PC_W  = 32,
  parameter int TID_W = 2,
  parameter int SETS  = 64,
  parameter int WAYS  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TID_W-1:0] lk_tid_i,
  input  logic [PC_W-3:0]  lk_wa_i,
  output logic             lk_hit_o,
  output logic [PC_W-1:0]  lk_target_o,
  output br_kind_e         lk_kind_o,
  input  logic             up_valid_i,
  input  logic [TID_W-1:0] up_tid_i,
  input  logic [PC_W-3:0]  up_wa_i,
  input  logic             up_taken_i,
  input  logic [PC_W-1:0]  up_target_i,
  input  br_kind_e         up_kind_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - 2 - IDX_W;

  logic [WAYS-1:0]  vld_q  [SETS];
  logic [TID_W-1:0] tid_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [PC_W-1:0]  tgt_q  [SETS][WAYS];
  br_kind_e         kind_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q  [SETS][WAYS];

  logic [IDX_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS-1:0]  lk_match, up_match;
  logic [WAY_W-1:0] hit_way, victim, wr_way;
  logic             up_hit, touch, wr_data;

  assign lk_set = lk_wa_i[IDX_W-1:0];
  assign lk_tag = lk_wa_i[PC_W-3:IDX_W];
  assign up_set = up_wa_i[IDX_W-1:0];
  assign up_tag = up_wa_i[PC_W-3:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_match[w] = vld_q[lk_set][w] && (tid_q[lk_set][w] == lk_tid_i)
                         && (tag_q[lk_set][w] == lk_tag);
    assign up_match[w] = vld_q[up_set][w] && (tid_q[up_set][w] == up_tid_i)
                         && (tag_q[up_set][w] == up_tag);
  end

  assign lk_hit_o = |lk_match;
  assign up_hit   = |up_match;

  always_comb begin
    lk_target_o = '0;
    lk_kind_o   = BR_COND;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) begin
        lk_target_o = tgt_q[lk_set][w];
        lk_kind_o   = kind_q[lk_set][w];
      end
    end
  end

  // hit way; victim = lowest invalid way, else the oldest way
  always_comb begin
    hit_way = '0;
    victim  = '0;
    for (int w = 0; w < WAYS; w++)
      if (up_match[w]) hit_way = WAY_W'(w);
    for (int w = WAYS-1; w >= 0; w--)
      if (age_q[up_set][w] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
    for (int w = WAYS-1; w >= 0; w--)
      if (!vld_q[up_set][w]) victim = WAY_W'(w);
  end

  assign wr_way  = up_hit ? hit_way : victim;
  assign touch   = up_valid_i && (up_hit || up_taken_i);
  assign wr_data = up_valid_i && up_taken_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          age_q[s][w] <= WAY_W'(w);
        end
    end else if (touch) begin
      vld_q[up_set][wr_way] <= 1'b1;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == wr_way)
          age_q[up_set][w] <= '0;
        else if (age_q[up_set][w] < age_q[up_set][wr_way])
          age_q[up_set][w] <= age_q[up_set][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_data) begin
      tid_q[up_set][wr_way]  <= up_tid_i;
      tag_q[up_set][wr_way]  <= up_tag;
      tgt_q[up_set][wr_way]  <= up_target_i;
      kind_q[up_set][wr_way] <= up_kind_i;
    end
  end

  // R2
  lk_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));

  // R3
  no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !up_taken_i && !up_hit) |=> vld_q[$past(up_set)] == $past(vld_q[up_set]));

  // R10
  mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch |=> (age_q[$past(up_set)][$past(wr_way)] == '0) && vld_q[$past(up_set)][$past(wr_way)]);
endmodule

// File: rtl/mtbp_pht.sv
`timescale 1ns/1ps
module mtbp_pht import mtbp_pkg::*; #(
  parameter int ENTRIES = 2048,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_bits_i,
  output logic             lk_taken_o,
  input  logic             up_en_i,
  input  logic [IDX_W-1:0] up_bits_i,
  input  logic             up_taken_i
);
  logic [1:0]       ctr_q [ENTRIES];
  logic [IDX_W-1:0] ghr_q;
  logic [IDX_W-1:0] lk_idx, up_idx;

  assign lk_idx     = lk_bits_i ^ ghr_q;
  assign up_idx     = up_bits_i ^ ghr_q;
  assign lk_taken_o = ctr_q[lk_idx][1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) ctr_q[e] <= 2'd1;
      ghr_q <= '0;
    end else if (up_en_i) begin
      ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken_i);
      ghr_q         <= {ghr_q[IDX_W-2:0], up_taken_i};
    end
  end

  // R6
  ghr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_i |=> ghr_q[0] == $past(up_taken_i));

  // R6
  ghr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_en_i |=> $stable(ghr_q));

  // R6
  ctr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_en_i && up_taken_i && ctr_q[up_idx] == 2'd3) |=> ctr_q[$past(up_idx)] == 2'd3);
endmodule

// File: rtl/mtbp_ras.sv
`timescale 1ns/1ps
module mtbp_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_data_i,
  output logic [PC_W-1:0] top_o,
  output logic            empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, top_idx;
  logic [CNT_W-1:0] cnt_q;

  // ptr_q points at the next free slot; the ring wraps
  assign top_idx = (ptr_q == '0) ? PTR_W'(DEPTH-1) : ptr_q - 1'b1;
  assign top_o   = mem_q[top_idx];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      ptr_q <= top_idx;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[ptr_q] <= push_data_i;
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R9
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !empty_o && top_o == $past(push_data_i));

  // R9
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o && $stable(ptr_q));
endmodule

// File: rtl/mtbp_predictor.sv
`timescale 1ns/1ps
module mtbp_predictor import mtbp_pkg::*; #(
  parameter int PC_W        = 32,
  parameter int THREADS     = 4,
  parameter int BTB_SETS    = 64,
  parameter int BTB_WAYS    = 4,
  parameter int PHT_ENTRIES = 2048,
  parameter int RAS_DEPTH   = 12,
  localparam int TID_W      = $clog2(THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TID_W-1:0] pred_tid_i,
  input  logic [PC_W-1:0]  pred_pc_i,
  output logic             pred_taken_o,
  output logic [PC_W-1:0]  pred_target_o,
  output logic             pred_hit_o,
  input  logic             upd_valid_i,
  input  logic [TID_W-1:0] upd_tid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_taken_i,
  input  logic [PC_W-1:0]  upd_target_i,
  input  logic [1:0]       upd_type_i
);
  localparam int PHT_W = $clog2(PHT_ENTRIES);

  br_kind_e        upd_kind, btb_kind;
  logic            btb_hit, pht_taken;
  logic [PC_W-1:0] btb_tgt, fall_pc;
  logic [PC_W-1:0] ras_top   [THREADS];
  logic [THREADS-1:0] ras_empty;

  assign upd_kind = br_kind_e'(upd_type_i);
  assign fall_pc  = pred_pc_i + PC_W'(4);

  mtbp_btb #(.PC_W(PC_W), .TID_W(TID_W), .SETS(BTB_SETS), .WAYS(BTB_WAYS)) u_btb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_tid_i    (pred_tid_i),
    .lk_wa_i     (pred_pc_i[PC_W-1:2]),
    .lk_hit_o    (btb_hit),
    .lk_target_o (btb_tgt),
    .lk_kind_o   (btb_kind),
    .up_valid_i  (upd_valid_i),
    .up_tid_i    (upd_tid_i),
    .up_wa_i     (upd_pc_i[PC_W-1:2]),
    .up_taken_i  (upd_taken_i),
    .up_target_i (upd_target_i),
    .up_kind_i   (upd_kind)
  );

  mtbp_pht #(.ENTRIES(PHT_ENTRIES)) u_pht (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_bits_i  (pred_pc_i[PHT_W+1:2]),
    .lk_taken_o (pht_taken),
    .up_en_i    (upd_valid_i && upd_kind == BR_COND),
    .up_bits_i  (upd_pc_i[PHT_W+1:2]),
    .up_taken_i (upd_taken_i)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_ras
    mtbp_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (upd_valid_i && upd_kind == BR_CALL && upd_tid_i == TID_W'(t)),
      .pop_i       (upd_valid_i && upd_kind == BR_RET  && upd_tid_i == TID_W'(t)),
      .push_data_i (upd_pc_i + PC_W'(4)),
      .top_o       (ras_top[t]),
      .empty_o     (ras_empty[t])
    );
  end

  always_comb begin
    pred_taken_o  = 1'b0;
    pred_target_o = fall_pc;
    if (btb_hit) begin
      unique case (btb_kind)
        BR_COND: begin
          pred_taken_o  = pht_taken;
          pred_target_o = pht_taken ? btb_tgt : fall_pc;
        end
        BR_JUMP, BR_CALL: begin
          pred_taken_o  = 1'b1;
          pred_target_o = btb_tgt;
        end
        BR_RET: begin
          pred_taken_o  = !ras_empty[pred_tid_i];
          pred_target_o = ras_empty[pred_tid_i] ? fall_pc : ras_top[pred_tid_i];
        end
        default: ;
      endcase
    end
  end

  assign pred_hit_o = btb_hit;

  // R4
  miss_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> !pred_taken_o && pred_target_o == pred_pc_i + PC_W'(4));

  // R7
  uncond_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_hit_o && (btb_kind == BR_JUMP || btb_kind == BR_CALL)) |-> pred_taken_o);

  // R8
  ret_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_hit_o && btb_kind == BR_RET && pred_taken_o) |-> pred_target_o == ras_top[pred_tid_i]);
endmodule

// File: tb/mtbp_predictor_test.sv
`timescale 1ns/1ps
module mtbp_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pred_tid = '0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken, pred_hit;
  logic [31:0] pred_target;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_tid = '0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic [1:0]  upd_type = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mtbp_predictor uut (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_tid_i(pred_tid), .pred_pc_i(pred_pc),
    .pred_taken_o(pred_taken), .pred_target_o(pred_target), .pred_hit_o(pred_hit),
    .upd_valid_i(upd_valid), .upd_tid_i(upd_tid), .upd_pc_i(upd_pc),
    .upd_taken_i(upd_taken), .upd_target_i(upd_target), .upd_type_i(upd_type)
  );

  // behavioural reference
  bit          m_v   [64][4];
  int          m_tid [64][4];
  logic [23:0] m_tag [64][4];
  logic [31:0] m_tgt [64][4];
  int          m_ty  [64][4];
  int          m_ord [64][4];   // recency list, index 0 = most recent
  int          m_ctr [2048];
  int          m_ghr;
  logic [31:0] m_ras [4][$];

  task automatic m_reset();
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 0; m_ord[s][w] = w;
      end
    for (int e = 0; e < 2048; e++) m_ctr[e] = 1;
    m_ghr = 0;
    for (int t = 0; t < 4; t++) m_ras[t].delete();
  endtask

  task automatic m_touch(int s, int w);
    int pos = 0;
    for (int i = 0; i < 4; i++) if (m_ord[s][i] == w) pos = i;
    for (int i = pos; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
    m_ord[s][0] = w;
  endtask

  function automatic int m_find(int tid, logic [31:0] pc);
    int s = int'(pc[7:2]);
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_tid[s][w] == tid && m_tag[s][w] == pc[31:8]) return w;
    return -1;
  endfunction

  task automatic m_pred(int tid, logic [31:0] pc, output bit hit, output bit tk,
                        output logic [31:0] tg, output string lbl);
    int s = int'(pc[7:2]);
    int w = m_find(tid, pc);
    hit = (w >= 0); tk = 0; tg = pc + 32'd4;
    if (!hit) begin
      lbl = "R4";
      for (int k = 0; k < 4; k++)
        if (m_v[s][k] && m_tag[s][k] == pc[31:8]) lbl = "R2";
    end else if (m_ty[s][w] == 0) begin
      lbl = "R5";
      if (m_ctr[int'(pc[12:2]) ^ m_ghr] >= 2) begin tk = 1; tg = m_tgt[s][w]; end
    end else if (m_ty[s][w] == 3) begin
      lbl = "R8";
      if (m_ras[tid].size() > 0) begin tk = 1; tg = m_ras[tid][0]; end
    end else begin
      lbl = "R7"; tk = 1; tg = m_tgt[s][w];
    end
  endtask

  task automatic m_update(int tid, logic [31:0] pc, bit tk, logic [31:0] tg, int ty);
    int s = int'(pc[7:2]);
    int w = m_find(tid, pc);
    if (ty == 0) begin
      int idx = int'(pc[12:2]) ^ m_ghr;
      if (tk && m_ctr[idx] < 3) m_ctr[idx]++;
      if (!tk && m_ctr[idx] > 0) m_ctr[idx]--;
      m_ghr = ((m_ghr << 1) | int'(tk)) & 2047;
    end
    if (ty == 2) begin
      m_ras[tid].push_front(pc + 32'd4);
      if (m_ras[tid].size() > 12) void'(m_ras[tid].pop_back());
    end
    if (ty == 3 && m_ras[tid].size() > 0) void'(m_ras[tid].pop_front());
    if (w < 0 && tk) begin
      w = m_ord[s][3];
      for (int k = 3; k >= 0; k--) if (!m_v[s][k]) w = k;
      m_v[s][w] = 1; m_tid[s][w] = tid; m_tag[s][w] = pc[31:8];
    end
    if (w >= 0) begin
      if (tk) begin m_tgt[s][w] = tg; m_ty[s][w] = ty; end
      m_touch(s, w);
    end
  endtask

  task automatic step(int ptid, logic [31:0] ppc, bit uv, int utid, logic [31:0] upc,
                      bit utk, logic [31:0] utg, int uty, string lbl);
    bit ehit, etk;
    logic [31:0] etg;
    string auto_lbl;
    @(negedge clk);
    pred_tid = 2'(ptid); pred_pc = ppc;
    upd_valid = uv; upd_tid = 2'(utid); upd_pc = upc;
    upd_taken = utk; upd_target = utg; upd_type = 2'(uty);
    #5;
    m_pred(ptid, ppc, ehit, etk, etg, auto_lbl);   // R11: model state is pre-update
    if (lbl == "") lbl = auto_lbl;
    checks++;
    if (pred_hit !== ehit || pred_taken !== etk || pred_target !== etg) begin
      errors++;
      $display("FAIL %s tid=%0d pc=%h: got hit=%b taken=%b tgt=%h, exp hit=%b taken=%b tgt=%h",
               lbl, ptid, ppc, pred_hit, pred_taken, pred_target, ehit, etk, etg);
    end
    @(posedge clk); #1;
    if (uv) m_update(utid, upc, utk, utg, uty);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1: empty state right after reset
    for (int i = 0; i < 8; i++) step(i % 4, 32'h100 + 32'(i * 4), 0, 0, 0, 0, 0, 0, "R1");

    // R2: phantom hit from another thread must not occur
    step(0, 0, 1, 0, 32'h1040, 1, 32'h2000, 1, "");
    step(1, 32'h1040, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 32'h1040, 0, 0, 0, 0, 0, 0, "R7");

    // R3: not-taken miss allocates nothing
    step(0, 0, 1, 0, 32'h3050, 0, 32'h4000, 0, "");
    step(0, 32'h3050, 0, 0, 0, 0, 0, 0, "R3");

    // R11: prediction and allocating update in the same cycle
    step(2, 32'h5060, 1, 2, 32'h5060, 1, 32'h6000, 1, "R11");
    step(2, 32'h5060, 0, 0, 0, 0, 0, 0, "R11");

    // R5 / R6: train one conditional up to saturation, then down
    step(0, 0, 1, 0, 32'h0800, 1, 32'h0900, 0, "");
    for (int i = 0; i < 16; i++) step(0, 32'h0800, 1, 0, 32'h0800, 1, 32'h0900, 0, "R6");
    for (int i = 0; i < 16; i++) step(0, 32'h0800, 1, 0, 32'h0800, 0, 32'h0900, 0, "R6");
    step(0, 32'h0800, 0, 0, 0, 0, 0, 0, "R5");

    // R8 / R9: return entry, empty stack, overflow and unwind
    step(2, 0, 1, 2, 32'h7070, 1, 32'h0, 3, "");
    step(2, 32'h7070, 0, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 14; i++)
      step(2, 32'h7070, 1, 2, 32'h9000 + 32'(i * 16), 1, 32'hA000, 2, "R9");
    for (int i = 0; i < 13; i++)
      step(2, 32'h7070, 1, 2, 32'h7070, 1, 32'h0, 3, "R9");

    // R10: fill one set beyond capacity, refresh one way, then probe every tag
    for (int k = 1; k <= 6; k++)
      step(3, 0, 1, 3, (32'(k) << 8) | 32'h14, 1, 32'h8000 + 32'(k * 256), 1, "");
    step(3, 0, 1, 3, (32'd3 << 8) | 32'h14, 1, 32'hBEE0, 1, "");
    step(3, 0, 1, 3, (32'd7 << 8) | 32'h14, 1, 32'hC000, 1, "");
    for (int k = 1; k <= 7; k++) step(3, (32'(k) << 8) | 32'h14, 0, 0, 0, 0, 0, 0, "R10");

    // mixed traffic on an aliasing pool
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ppc, upc;
      ppc = (32'($urandom_range(0, 7)) << 8) | (32'($urandom_range(0, 3)) << 2);
      upc = (32'($urandom_range(0, 7)) << 8) | (32'($urandom_range(0, 3)) << 2);
      step(int'($urandom_range(0, 3)), ppc, $urandom_range(0, 9) < 7,
           int'($urandom_range(0, 3)), upc, bit'($urandom_range(0, 1)),
           32'($urandom_range(0, 65535)) << 2, int'($urandom_range(0, 3)), "");
    end

    finish_run();
  end
endmodule